// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Guard

This block sits beside the bit engine of an I2C master and watches for lost arbitration. While the master is in a START, repeated START, address, data, acknowledge or STOP phase, the block compares the level the master intends on SDA with the level it samples on the wire. If the master is releasing SDA to 1 and the line reads 0 while SCL is high, another master has won the bus.

On that mismatch the block does several things. It sets a sticky collision flag and gives a one-cycle abort strobe. It releases both lines. It clears the buffer-full flag when a byte was being shifted, and it cancels the request bit of the condition in progress. It also marks the next transmission to begin again at its first bit.

After a collision the block keeps watching the bus. When a STOP condition appears, it raises a one-cycle interrupt strobe so that software knows the bus is free. Both SDA and SCL arrive already synchronized. SDA is compared only once SCL has been high for at least one clock, which leaves time for the synchronizer.

Top module: `i2c_arb_guard`

## Requirements
- R1: After reset, coll_flag, abort_stb, bf_clr, cond_clr, bit_rst, stop_irq, tx_block, sda_rel and scl_rel are all 0.
- R2: A collision is detected in a cycle when all of the following hold: busy is 1, phase is one of 1..6 (1 START, 2 repeated START, 3 address, 4 data, 5 acknowledge, 6 STOP), drv_sda is 1, sda_in is 0, scl_in is 1 in this cycle and was 1 in the previous cycle, and coll_flag is 0. On the next clock edge coll_flag becomes 1.
- R3: No collision is detected when any of the following holds: drv_sda is 0, scl_in is 0, scl_in has only just risen, phase is 0 (idle), or busy is 0.
- R4: abort_stb is high for exactly the one cycle after a detection.
- R5: bf_clr pulses together with abort_stb when the detection happened in phase 3 or phase 4.
- R6: cond_clr pulses together with abort_stb, and at most one of its bits is set. Bit 0 is set for phase 1, bit 1 for phase 2, bit 2 for phase 6 and bit 3 for phase 5.
- R7: sda_rel and scl_rel are 1 while coll_flag is 1.
- R8: coll_flag stays set until sw_clr is 1. While coll_flag is set, no new detection occurs and tx_block is 1.
- R9: After a collision, bit_rst pulses for one cycle after the first buf_wr that is accepted. A buf_wr is accepted when coll_flag is 0 and the cycle is not a detection cycle.
- R10: After a collision, the first STOP seen on the bus pulses stop_irq for one cycle. A STOP is SDA going from 0 to 1 while SCL is 1 in both cycles. The STOP also ends the watch, so later STOPs give no pulse until the next collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| busy | input | 1 | Master operation active |
| phase | input | 3 | Current phase code |
| drv_sda | input | 1 | Intended SDA level (1 = released) |
| sda_in | input | 1 | Synchronized SDA |
| scl_in | input | 1 | Synchronized SCL |
| buf_wr | input | 1 | Write to the transmit buffer |
| sw_clr | input | 1 | Software clear of the collision flag |
| coll_flag | output | 1 | Sticky collision flag |
| abort_stb | output | 1 | One-cycle abort strobe |
| sda_rel | output | 1 | Force SDA released |
| scl_rel | output | 1 | Force SCL released |
| bf_clr | output | 1 | Clear strobe for the buffer-full flag |
| cond_clr | output | 4 | Clear strobes for condition requests |
| bit_rst | output | 1 | Restart the next transmission at bit 0 |
| stop_irq | output | 1 | STOP seen after a collision |
| tx_block | output | 1 | New transmissions blocked |

## Verification
The hardest situation to reach from the ports is a STOP after a collision. It needs a collision, then a low SDA while SCL is held high, then SDA rising while SCL stays high. Random toggling of the lines rarely produces that ordering. Directed sequences build it step by step: first a collision, then a STOP while the flag is still set, then a second STOP to confirm that no pulse follows it. Other directed sequences cover a collision on a cycle in which buf_wr is also asserted. Random stimulus then holds SCL high for several cycles at a time and mixes rare clears and buffer writes, and a reference model in the bench predicts every strobe.

// File: rtl/i2c_arb_guard.sv
module i2c_arb_guard (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic [2:0] phase,
  input  logic       drv_sda,
  input  logic       sda_in,
  input  logic       scl_in,
  input  logic       buf_wr,
  input  logic       sw_clr,
  output logic       coll_flag,
  output logic       abort_stb,
  output logic       sda_rel,
  output logic       scl_rel,
  output logic       bf_clr,
  output logic [3:0] cond_clr,
  output logic       bit_rst,
  output logic       stop_irq,
  output logic       tx_block
);
  localparam logic [2:0] PH_IDLE = 3'd0;
  localparam logic [2:0] PH_STA  = 3'd1;
  localparam logic [2:0] PH_RSTA = 3'd2;
  localparam logic [2:0] PH_ADDR = 3'd3;
  localparam logic [2:0] PH_DATA = 3'd4;
  localparam logic [2:0] PH_ACK  = 3'd5;
  localparam logic [2:0] PH_STOP = 3'd6;

  logic scl_q, sda_q, pend, watch;
  logic phase_ok, hit, stop_det, accept;

  assign phase_ok = (phase != PH_IDLE) && (phase <= PH_STOP);
  assign hit      = busy && phase_ok && drv_sda && !sda_in && scl_in && scl_q && !coll_flag;
  assign stop_det = scl_q && scl_in && !sda_q && sda_in;
  assign accept   = buf_wr && !coll_flag && !hit;

  assign sda_rel  = coll_flag;
  assign scl_rel  = coll_flag;
  assign tx_block = coll_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      coll_flag <= 1'b0;
      abort_stb <= 1'b0;
      bf_clr    <= 1'b0;
      cond_clr  <= '0;
      pend      <= 1'b0;
      watch     <= 1'b0;
      bit_rst   <= 1'b0;
      stop_irq  <= 1'b0;
    end else begin
      scl_q     <= scl_in;
      sda_q     <= sda_in;
      abort_stb <= hit;
      bf_clr    <= hit && (phase == PH_ADDR || phase == PH_DATA);
      cond_clr  <= {hit && phase == PH_ACK, hit && phase == PH_STOP,
                    hit && phase == PH_RSTA, hit && phase == PH_STA};
      if (hit)         coll_flag <= 1'b1;
      else if (sw_clr) coll_flag <= 1'b0;
      bit_rst <= pend && accept;
      if (hit)         pend <= 1'b1;
      else if (accept) pend <= 1'b0;
      stop_irq <= watch && stop_det;
      if (hit)           watch <= 1'b1;
      else if (stop_det) watch <= 1'b0;
    end
  end

  assert_detect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase_ok && drv_sda && !sda_in && scl_in && scl_q && !coll_flag) |=> coll_flag);
  assert_no_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!coll_flag && (!scl_q || !drv_sda || !busy)) |=> !abort_stb);
  assert_abort_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_stb |=> !abort_stb);
  assert_bf_with_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bf_clr |-> abort_stb && coll_flag);
  assert_cond_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cond_clr) && ((|cond_clr) -> abort_stb));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_flag && !sw_clr) |=> coll_flag);
  assert_stop_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq |=> !stop_irq);
endmodule

// File: tb/tb_i2c_arb_guard.sv
module tb_i2c_arb_guard;
  logic clk = 1'b0, rst_n = 1'b0;
  logic busy = 0, drv_sda = 1, sda_in = 1, scl_in = 1, buf_wr = 0, sw_clr = 0;
  logic [2:0] phase = 0;
  logic coll_flag, abort_stb, sda_rel, scl_rel, bf_clr, bit_rst, stop_irq, tx_block;
  logic [3:0] cond_clr;

  always #4 clk = ~clk;

  i2c_arb_guard dut (.clk(clk), .rst_n(rst_n), .busy(busy), .phase(phase),
    .drv_sda(drv_sda), .sda_in(sda_in), .scl_in(scl_in), .buf_wr(buf_wr),
    .sw_clr(sw_clr), .coll_flag(coll_flag), .abort_stb(abort_stb),
    .sda_rel(sda_rel), .scl_rel(scl_rel), .bf_clr(bf_clr), .cond_clr(cond_clr),
    .bit_rst(bit_rst), .stop_irq(stop_irq), .tx_block(tx_block));

  int errors = 0, checks = 0;
  bit done = 0;
  logic m_scl = 1, m_sda = 1, m_coll = 0, m_pend = 0, m_watch = 0;
  logic e_abort = 0, e_bf = 0, e_bit = 0, e_stop = 0;
  logic [3:0] e_cond = 0;

  function automatic logic [3:0] cond_code(input logic [2:0] p);
    case (p)
      3'd1: return 4'b0001;
      3'd2: return 4'b0010;
      3'd6: return 4'b0100;
      3'd5: return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic b, input logic [2:0] p, input logic d,
                      input logic sda, input logic scl, input logic w, input logic c);
    logic hit, sdet, acc;
    busy = b; phase = p; drv_sda = d; sda_in = sda; scl_in = scl; buf_wr = w; sw_clr = c;
    hit  = b && (p >= 3'd1 && p <= 3'd6) && d && !sda && scl && m_scl && !m_coll;
    sdet = m_scl && scl && !m_sda && sda;
    acc  = w && !m_coll && !hit;
    e_abort = hit;
    e_bf    = hit && (p == 3'd3 || p == 3'd4);
    e_cond  = hit ? cond_code(p) : 4'b0000;
    e_bit   = m_pend && acc;
    e_stop  = m_watch && sdet;
    if (hit) m_coll = 1; else if (c) m_coll = 0;
    if (hit) m_pend = 1; else if (acc) m_pend = 0;
    if (hit) m_watch = 1; else if (sdet) m_watch = 0;
    m_scl = scl; m_sda = sda;
    @(negedge clk);
    chk(coll_flag == m_coll, "R2/R3/R8 coll_flag", coll_flag, m_coll);
    chk(abort_stb == e_abort, "R4 abort_stb", abort_stb, e_abort);
    chk(bf_clr == e_bf, "R5 bf_clr", bf_clr, e_bf);
    chk(cond_clr == e_cond, "R6 cond_clr", cond_clr, e_cond);
    chk(sda_rel == m_coll && scl_rel == m_coll, "R7 release", {sda_rel, scl_rel}, {m_coll, m_coll});
    chk(tx_block == m_coll, "R8 tx_block", tx_block, m_coll);
    chk(bit_rst == e_bit, "R9 bit_rst", bit_rst, e_bit);
    chk(stop_irq == e_stop, "R10 stop_irq", stop_irq, e_stop);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    chk({coll_flag, abort_stb, bf_clr, cond_clr, bit_rst, stop_irq, tx_block, sda_rel, scl_rel} == 0,
        "R1 reset outputs", coll_flag, 0);
    rst_n = 1;
    @(negedge clk);
    // R3: SCL just rose, no detection
    step(1, 3'd3, 1, 0, 0, 0, 0);
    step(1, 3'd3, 1, 0, 1, 0, 0);
    // R3: driving low, idle phase, not busy
    step(1, 3'd3, 0, 0, 1, 0, 0);
    step(1, 3'd0, 1, 0, 1, 0, 0);
    step(0, 3'd4, 1, 0, 1, 0, 0);
    // R2, R5: collision in each phase, cleared between
    for (int p = 1; p <= 6; p++) begin
      step(1, 3'(p), 1, 0, 1, 0, 0);
      step(1, 3'(p), 1, 0, 1, 0, 0);
      step(1, 3'(p), 1, 1, 1, 1, 0);
      step(1, 3'(p), 1, 1, 1, 0, 1);
      step(1, 3'(p), 1, 1, 1, 1, 0);
    end
    // R10: collision, then STOP while still flagged, then a second STOP
    step(1, 3'd4, 1, 0, 1, 0, 0);
    step(0, 3'd0, 1, 0, 1, 0, 0);
    step(0, 3'd0, 1, 1, 1, 0, 0);
    step(0, 3'd0, 1, 0, 1, 0, 0);
    step(0, 3'd0, 1, 1, 1, 0, 0);
    step(0, 3'd0, 1, 1, 1, 0, 1);
    // R9: buffer write in a detection cycle is not accepted
    step(1, 3'd4, 1, 0, 1, 1, 0);
    step(1, 3'd4, 1, 1, 1, 0, 1);
    step(1, 3'd4, 1, 1, 1, 1, 0);
    step(1, 3'd4, 1, 1, 1, 1, 0);
    for (int i = 0; i < 4000; i++) begin
      logic scl;
      scl = ($urandom_range(0, 5) != 0) ? m_scl : ~m_scl;
      step($urandom_range(0, 7) != 0, 3'($urandom_range(0, 7)), $urandom_range(0, 3) != 0,
           $urandom_range(0, 2) != 0, scl, $urandom_range(0, 9) == 0, $urandom_range(0, 14) == 0);
    end
    done = 1;
    summary();
  end
endmodule